// File: doc/BRIEF.md
# VEX Prefix Byte-Stream Parser

This block sits in an instruction-fetch path where bytes arrive one per cycle over a valid/ready handshake. It starts at a byte position where a prefix may begin, works out whether a two-byte or three-byte VEX prefix starts there, and gathers its bytes. It then collects the byte that follows the prefix and presents one decoded record. The record carries the true (uncomplemented) register-extension bits, the operand-width bit, the extra source register, the vector length, the implied SIMD prefix code and the opcode-map select. It also carries a reserved-map flag and a not-VEX flag. Opcode, ModRM/SIB, displacement, immediate and operand-suffix decoding are left to later stages.

A mode input gives the execution width. In 32-bit mode the lead bytes 0xC4/0xC5 double as the legacy far-pointer load opcodes. The parser peeks at the following byte and treats the pair as VEX only when that byte has its two top bits set. Otherwise it hands both bytes on untouched with the not-VEX flag. The mode is latched together with the lead byte, so it cannot change partway through a prefix.

Top module: `vex_prefix_parser`

## Requirements
- R1: A lead byte of 0xC4 starts a three-byte prefix (out_three_byte=1) and 0xC5 starts a two-byte prefix. Any other lead byte is consumed alone and yields out_is_vex=0, out_follow_valid=0, out_lead equal to that byte, and all decoded fields zero.
- R2: In the three-byte form, the second byte holds complemented R, X, B in bits 7, 6, 5 and the map select in bits 4..0. The third byte holds W in bit 7, complemented vvvv in bits 6..3, L in bit 2 and pp in bits 1..0. In 64-bit mode out_ext_r/x/b are the true values of R, X and B.
- R3: In the two-byte form, the second byte holds complemented R in bit 7, complemented vvvv in bits 6..3, L in bit 2 and pp in bits 1..0. The record then reports out_ext_x=0, out_ext_b=0, out_w=0 and out_map=1.
- R4: out_src2 is the complement of the encoded vvvv. An encoded 1111 gives out_src2_used=0 and out_src2=0. Any other value gives out_src2_used=1.
- R5: Map select values 1, 2 and 3 (maps 0F, 0F38, 0F3A) are valid. Every other value (0 and 4..31) sets out_map_rsvd=1. out_map always carries the raw select value.
- R6: out_simd carries pp unchanged (00 none, 01 0x66, 10 0xF3, 11 0xF2). out_len256 carries L (0 means 128-bit, 1 means 256-bit).
- R7: In 32-bit mode (mode64=0), a 0xC4/0xC5 lead is VEX only if the next byte has bits 7..6 equal to 11. Otherwise out_is_vex=0, out_lead is the lead byte, out_follow is the next byte, out_follow_valid=1, and all decoded fields are zero.
- R8: In 32-bit mode a VEX record reports out_ext_r, out_ext_x and out_ext_b as 0. In 64-bit mode 0xC4/0xC5 always starts a VEX prefix, whatever the next byte is.
- R9: For a VEX prefix, the byte after the prefix is consumed and shown on out_follow with out_follow_valid=1, and out_lead shows the lead byte.
- R10: The record stays stable with out_valid=1 until out_ready is seen high at a clock edge. While out_valid=1, in_ready=0 and no input byte is taken.
- R11: Reset returns the parser to idle with out_valid=0 and in_ready=1. Any partly gathered prefix is discarded, and the next byte accepted is treated as a lead byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode; sampled with the lead byte |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Parser can take a byte |
| out_valid | output | 1 | Decoded record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_is_vex | output | 1 | A VEX prefix was found |
| out_three_byte | output | 1 | Three-byte form |
| out_map_rsvd | output | 1 | Map select is reserved |
| out_ext_r | output | 1 | True R extension bit |
| out_ext_x | output | 1 | True X extension bit |
| out_ext_b | output | 1 | True B extension bit |
| out_w | output | 1 | Operand-width / opcode-extension bit |
| out_src2 | output | 4 | Extra source register number |
| out_src2_used | output | 1 | Extra source register present |
| out_len256 | output | 1 | 256-bit vector length |
| out_simd | output | 2 | Implied SIMD prefix code |
| out_map | output | 5 | Opcode-map select |
| out_lead | output | 8 | Lead byte |
| out_follow | output | 8 | Byte after the prefix, or the byte peeked in 32-bit mode |
| out_follow_valid | output | 1 | out_follow holds a consumed byte |

## Verification
The bench builds the parser with its default MAP_LAST of 3, so three valid maps and the reserved selects 0, 4 and 31 are all reachable through byte values alone. The vector table covers both prefix forms in both modes. That includes a 64-bit second byte whose top bits are 00, which still decodes as VEX. Directed runs hold a record under back-pressure while an input byte waits, and pull reset in the middle of a prefix to show that the next byte is parsed as a fresh lead.

// File: rtl/vex_pkg.sv
package vex_pkg;

  localparam int BYTE_W  = 8;
  localparam int REG_W   = 4;
  localparam int MAP_W   = 5;
  localparam int SIMD_W  = 2;

  localparam logic [BYTE_W-1:0] LEAD_LONG  = 8'hC4;
  localparam logic [BYTE_W-1:0] LEAD_SHORT = 8'hC5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SECOND,
    ST_THIRD,
    ST_FOLLOW,
    ST_HOLD
  } pstate_e;

  typedef enum logic [1:0] {
    KIND_PLAIN,
    KIND_LEGACY,
    KIND_SHORT,
    KIND_LONG
  } kind_e;

  typedef struct packed {
    logic              is_vex;
    logic              three_byte;
    logic              map_rsvd;
    logic              ext_r;
    logic              ext_x;
    logic              ext_b;
    logic              w;
    logic [REG_W-1:0]  src2;
    logic              src2_used;
    logic              len256;
    logic [SIMD_W-1:0] simd;
    logic [MAP_W-1:0]  map;
    logic [BYTE_W-1:0] lead;
    logic [BYTE_W-1:0] follow;
    logic              follow_valid;
  } vex_rec_t;

endpackage

// File: rtl/vex_lead_classify.sv
module vex_lead_classify
  import vex_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output logic              lead_any_o,
  output logic              lead_long_o,
  output logic              reg_form_o
);

  always_comb begin
    lead_long_o = (byte_i == LEAD_LONG);
    lead_any_o  = lead_long_o || (byte_i == LEAD_SHORT);
    // A second byte with both top bits set cannot be a memory-form ModRM.
    reg_form_o  = &byte_i[BYTE_W-1:BYTE_W-2];
  end

endmodule

// File: rtl/vex_seq_ctrl.sv
module vex_seq_ctrl
  import vex_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode64,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              out_ready,
  input  logic              lead_any,
  input  logic              lead_long,
  input  logic              reg_form,
  output logic              in_ready,
  output logic              out_valid,
  output kind_e             kind_q,
  output logic              mode_q,
  output logic [BYTE_W-1:0] lead_q,
  output logic [BYTE_W-1:0] second_q,
  output logic [BYTE_W-1:0] third_q,
  output logic [BYTE_W-1:0] follow_q
);

  pstate_e state_q, state_d;
  kind_e   kind_d;
  logic    take;
  logic    ld_lead, ld_second, ld_third, ld_follow, ld_kind;

  assign in_ready  = (state_q != ST_HOLD);
  assign out_valid = (state_q == ST_HOLD);
  assign take      = in_valid && in_ready;

  always_comb begin
    state_d   = state_q;
    kind_d    = kind_q;
    ld_lead   = 1'b0;
    ld_second = 1'b0;
    ld_third  = 1'b0;
    ld_follow = 1'b0;
    ld_kind   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (take) begin
          ld_lead = 1'b1;
          ld_kind = 1'b1;
          if (lead_any) begin
            kind_d  = lead_long ? KIND_LONG : KIND_SHORT;
            state_d = ST_SECOND;
          end else begin
            kind_d  = KIND_PLAIN;
            state_d = ST_HOLD;
          end
        end
      end
      ST_SECOND: begin
        if (take) begin
          ld_second = 1'b1;
          if (!mode_q && !reg_form) begin
            ld_follow = 1'b1;
            ld_kind   = 1'b1;
            kind_d    = KIND_LEGACY;
            state_d   = ST_HOLD;
          end else if (kind_q == KIND_LONG) begin
            state_d = ST_THIRD;
          end else begin
            state_d = ST_FOLLOW;
          end
        end
      end
      ST_THIRD: begin
        if (take) begin
          ld_third = 1'b1;
          state_d  = ST_FOLLOW;
        end
      end
      ST_FOLLOW: begin
        if (take) begin
          ld_follow = 1'b1;
          state_d   = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (out_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q   <= KIND_PLAIN;
      mode_q   <= 1'b0;
      lead_q   <= '0;
      second_q <= '0;
      third_q  <= '0;
      follow_q <= '0;
    end else begin
      if (ld_kind) kind_q <= kind_d;
      if (ld_lead) begin
        lead_q   <= in_byte;
        mode_q   <= mode64;
        follow_q <= '0;
      end
      if (ld_second) second_q <= in_byte;
      if (ld_third)  third_q  <= in_byte;
      if (ld_follow) follow_q <= in_byte;
    end
  end

endmodule

// File: rtl/vex_field_decode.sv
module vex_field_decode
  import vex_pkg::*;
#(
  parameter int MAP_LAST = 3
) (
  input  kind_e             kind,
  input  logic              mode64,
  input  logic [BYTE_W-1:0] lead,
  input  logic [BYTE_W-1:0] second,
  input  logic [BYTE_W-1:0] third,
  input  logic [BYTE_W-1:0] follow,
  output vex_rec_t          rec
);

  localparam int VV_LO = 3;
  localparam int VV_HI = VV_LO + REG_W - 1;

  logic              r_n, x_n, b_n;
  logic [REG_W-1:0]  vv_n;
  logic [MAP_W-1:0]  map_sel;
  logic              wbit, lbit;
  logic [SIMD_W-1:0] pp;
  logic [BYTE_W-1:0] vl_byte;

  always_comb begin
    vl_byte = (kind == KIND_LONG) ? third : second;
    vv_n    = vl_byte[VV_HI:VV_LO];
    lbit    = vl_byte[2];
    pp      = vl_byte[SIMD_W-1:0];
    r_n     = second[7];
    if (kind == KIND_LONG) begin
      x_n     = second[6];
      b_n     = second[5];
      map_sel = second[MAP_W-1:0];
      wbit    = third[7];
    end else begin
      x_n     = 1'b1;
      b_n     = 1'b1;
      map_sel = MAP_W'(1);
      wbit    = 1'b0;
    end
  end

  always_comb begin
    rec        = '0;
    rec.lead   = lead;
    rec.follow = follow;
    unique case (kind)
      KIND_PLAIN: begin
        rec.follow = '0;
      end
      KIND_LEGACY: begin
        rec.follow_valid = 1'b1;
      end
      KIND_SHORT, KIND_LONG: begin
        rec.is_vex       = 1'b1;
        rec.three_byte   = (kind == KIND_LONG);
        rec.ext_r        = mode64 & ~r_n;
        rec.ext_x        = mode64 & ~x_n;
        rec.ext_b        = mode64 & ~b_n;
        rec.w            = wbit;
        rec.src2_used    = ~&vv_n;
        rec.src2         = ~vv_n;
        rec.len256       = lbit;
        rec.simd         = pp;
        rec.map          = map_sel;
        rec.map_rsvd     = (map_sel == '0) || (int'(map_sel) > MAP_LAST);
        rec.follow_valid = 1'b1;
      end
      default: rec = '0;
    endcase
  end

endmodule

// File: rtl/vex_prefix_parser.sv
module vex_prefix_parser
  import vex_pkg::*;
#(
  parameter int MAP_LAST = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode64,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        in_ready,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        out_is_vex,
  output logic        out_three_byte,
  output logic        out_map_rsvd,
  output logic        out_ext_r,
  output logic        out_ext_x,
  output logic        out_ext_b,
  output logic        out_w,
  output logic [3:0]  out_src2,
  output logic        out_src2_used,
  output logic        out_len256,
  output logic [1:0]  out_simd,
  output logic [4:0]  out_map,
  output logic [7:0]  out_lead,
  output logic [7:0]  out_follow,
  output logic        out_follow_valid
);

  logic              lead_any, lead_long, reg_form;
  kind_e             kind_q;
  logic              mode_q;
  logic [BYTE_W-1:0] lead_q, second_q, third_q, follow_q;
  vex_rec_t          rec;

  vex_lead_classify i_classify (
    .byte_i      (in_byte),
    .lead_any_o  (lead_any),
    .lead_long_o (lead_long),
    .reg_form_o  (reg_form)
  );

  vex_seq_ctrl i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode64    (mode64),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .out_ready (out_ready),
    .lead_any  (lead_any),
    .lead_long (lead_long),
    .reg_form  (reg_form),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .kind_q    (kind_q),
    .mode_q    (mode_q),
    .lead_q    (lead_q),
    .second_q  (second_q),
    .third_q   (third_q),
    .follow_q  (follow_q)
  );

  vex_field_decode #(.MAP_LAST(MAP_LAST)) i_decode (
    .kind   (kind_q),
    .mode64 (mode_q),
    .lead   (lead_q),
    .second (second_q),
    .third  (third_q),
    .follow (follow_q),
    .rec    (rec)
  );

  assign out_is_vex       = rec.is_vex;
  assign out_three_byte   = rec.three_byte;
  assign out_map_rsvd     = rec.map_rsvd;
  assign out_ext_r        = rec.ext_r;
  assign out_ext_x        = rec.ext_x;
  assign out_ext_b        = rec.ext_b;
  assign out_w            = rec.w;
  assign out_src2         = rec.src2;
  assign out_src2_used    = rec.src2_used;
  assign out_len256       = rec.len256;
  assign out_simd         = rec.simd;
  assign out_map          = rec.map;
  assign out_lead         = rec.lead;
  assign out_follow       = rec.follow;
  assign out_follow_valid = rec.follow_valid;

endmodule

// File: rtl/vex_prefix_parser_chk.sv
module vex_prefix_parser_chk #(
  parameter int MAP_LAST = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_is_vex,
  input logic       out_three_byte,
  input logic       out_map_rsvd,
  input logic       out_ext_x,
  input logic       out_ext_b,
  input logic       out_w,
  input logic [3:0] out_src2,
  input logic       out_src2_used,
  input logic [4:0] out_map,
  input logic [7:0] out_lead,
  input logic [7:0] out_follow,
  input logic       out_follow_valid
);

  always_comb begin
    if (!rst_n) begin
      a_r11_reset_idle: assert (!out_valid && in_ready);
    end
  end

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_is_vex, out_three_byte, out_map, out_src2, out_lead, out_follow}));

  a_r10_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r5_rsvd_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_map_rsvd |-> out_is_vex && (out_map == 5'd0 || int'(out_map) > MAP_LAST));

  a_r3_short_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_vex && !out_three_byte |->
      out_map == 5'd1 && !out_ext_x && !out_ext_b && !out_w && out_lead == 8'hC5);

  a_r4_no_src_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_src2_used |-> out_src2 == 4'd0);

  a_r1_plain_clean: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_is_vex |-> !out_map_rsvd && !out_src2_used && out_map == 5'd0);

  a_r9_follow_present: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_vex |-> out_follow_valid);

endmodule

bind vex_prefix_parser vex_prefix_parser_chk #(.MAP_LAST(MAP_LAST)) i_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .in_ready         (in_ready),
  .out_valid        (out_valid),
  .out_ready        (out_ready),
  .out_is_vex       (out_is_vex),
  .out_three_byte   (out_three_byte),
  .out_map_rsvd     (out_map_rsvd),
  .out_ext_x        (out_ext_x),
  .out_ext_b        (out_ext_b),
  .out_w            (out_w),
  .out_src2         (out_src2),
  .out_src2_used    (out_src2_used),
  .out_map          (out_map),
  .out_lead         (out_lead),
  .out_follow       (out_follow),
  .out_follow_valid (out_follow_valid)
);

// File: tb/test_vex_prefix_parser.sv
module test_vex_prefix_parser;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode64 = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_ready = 1'b0;
  logic       in_ready, out_valid;
  logic       out_is_vex, out_three_byte, out_map_rsvd;
  logic       out_ext_r, out_ext_x, out_ext_b, out_w;
  logic [3:0] out_src2;
  logic       out_src2_used, out_len256;
  logic [1:0] out_simd;
  logic [4:0] out_map;
  logic [7:0] out_lead, out_follow;
  logic       out_follow_valid;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit ended  = 1'b0;

  always #2 clk = ~clk;

  vex_prefix_parser i_vex_prefix_parser (
    .clk(clk), .rst_n(rst_n), .mode64(mode64),
    .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_is_vex(out_is_vex), .out_three_byte(out_three_byte),
    .out_map_rsvd(out_map_rsvd), .out_ext_r(out_ext_r),
    .out_ext_x(out_ext_x), .out_ext_b(out_ext_b), .out_w(out_w),
    .out_src2(out_src2), .out_src2_used(out_src2_used),
    .out_len256(out_len256), .out_simd(out_simd), .out_map(out_map),
    .out_lead(out_lead), .out_follow(out_follow),
    .out_follow_valid(out_follow_valid)
  );

  // Expected record: vex three rsvd r x b w src2 used len simd map follow fvalid lead
  typedef struct packed {
    logic       m64;
    logic [2:0] nb;
    logic [7:0] b0, b1, b2, b3;
    logic       vex, three, rsvd, r, x, b, w;
    logic [3:0] s2;
    logic       used, l;
    logic [1:0] pp;
    logic [4:0] map;
    logic [7:0] fol;
    logic       fv;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    // R2 R4 R6: three-byte, nothing extended, no extra source
    '{1'b1,3'd4,8'hC4,8'hE1,8'h7D,8'h58, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 4'h0,1'b0,1'b1,2'b01,5'd1, 8'h58,1'b1,4'd2},
    // R2: all extensions set, W=1, vvvv encodes 15
    '{1'b1,3'd4,8'hC4,8'h02,8'h85,8'h18, 1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1, 4'hF,1'b1,1'b1,2'b01,5'd2, 8'h18,1'b1,4'd2},
    // R4 R6: map 3, src 6, pp=10
    '{1'b1,3'd4,8'hC4,8'h43,8'h4A,8'h0F, 1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0, 4'h6,1'b1,1'b0,2'b10,5'd3, 8'h0F,1'b1,4'd4},
    // R5: map select 0 reserved
    '{1'b1,3'd4,8'hC4,8'hE0,8'h78,8'h11, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 4'h0,1'b0,1'b0,2'b00,5'd0, 8'h11,1'b1,4'd5},
    // R5: map select 4 reserved, pp=11
    '{1'b1,3'd4,8'hC4,8'hE4,8'hFB,8'h22, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 4'h0,1'b0,1'b0,2'b11,5'd4, 8'h22,1'b1,4'd5},
    // R5: map select 31 reserved
    '{1'b1,3'd4,8'hC4,8'h1F,8'h00,8'hAA, 1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0, 4'hF,1'b1,1'b0,2'b00,5'd31,8'hAA,1'b1,4'd5},
    // R3: two-byte, no extension
    '{1'b1,3'd3,8'hC5,8'hFC,8'h77,8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'h0,1'b0,1'b1,2'b00,5'd1, 8'h77,1'b1,4'd3},
    // R3 R9: two-byte, R set, src 6
    '{1'b1,3'd3,8'hC5,8'h49,8'h59,8'h00, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 4'h6,1'b1,1'b0,2'b01,5'd1, 8'h59,1'b1,4'd9},
    // R8: 64-bit mode, second byte top bits 00 still VEX
    '{1'b1,3'd3,8'hC5,8'h35,8'hC4,8'h00, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 4'h9,1'b1,1'b1,2'b01,5'd1, 8'hC4,1'b1,4'd8},
    // R7: 32-bit legacy opcode, pair passed through
    '{1'b0,3'd2,8'hC4,8'h62,8'h00,8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'h0,1'b0,1'b0,2'b00,5'd0, 8'h62,1'b1,4'd7},
    '{1'b0,3'd2,8'hC5,8'h00,8'h00,8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'h0,1'b0,1'b0,2'b00,5'd0, 8'h00,1'b1,4'd7},
    // R8: 32-bit VEX, extensions forced to zero
    '{1'b0,3'd4,8'hC4,8'hC1,8'h05,8'h59, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 4'hF,1'b1,1'b1,2'b01,5'd1, 8'h59,1'b1,4'd8},
    '{1'b0,3'd3,8'hC5,8'hC5,8'h90,8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'h7,1'b1,1'b1,2'b01,5'd1, 8'h90,1'b1,4'd8},
    // R1: plain byte consumed alone
    '{1'b1,3'd1,8'h90,8'h00,8'h00,8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'h0,1'b0,1'b0,2'b00,5'd0, 8'h00,1'b0,4'd1}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finish_run();
    end
  end

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_rec();
    while (!out_valid) @(negedge clk);
  endtask

  task automatic pop();
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  function automatic logic [36:0] actual_rec();
    return {out_is_vex, out_three_byte, out_map_rsvd, out_ext_r, out_ext_x, out_ext_b,
            out_w, out_src2, out_src2_used, out_len256, out_simd, out_map,
            out_follow, out_follow_valid, out_lead};
  endfunction

  initial begin
    logic [36:0] held;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(!out_valid && in_ready, "R11", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R11", {out_valid, in_ready}, 2'b01);

    // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [36:0] exp;
      mode64 = VEC[i].m64;
      push(VEC[i].b0);
      if (VEC[i].nb > 1) push(VEC[i].b1);
      if (VEC[i].nb > 2) push(VEC[i].b2);
      if (VEC[i].nb > 3) push(VEC[i].b3);
      wait_rec();
      exp = {VEC[i].vex, VEC[i].three, VEC[i].rsvd, VEC[i].r, VEC[i].x, VEC[i].b,
             VEC[i].w, VEC[i].s2, VEC[i].used, VEC[i].l, VEC[i].pp, VEC[i].map,
             VEC[i].fol, VEC[i].fv, VEC[i].b0};
      check(actual_rec() == exp, $sformatf("R%0d vec%0d", VEC[i].req, i),
            64'(actual_rec()), 64'(exp));
      pop();
    end

    // R10: hold under back-pressure with a byte waiting
    mode64 = 1'b1;
    push(8'hC5); push(8'hF8); push(8'h10);
    wait_rec();
    held = actual_rec();
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = 8'h90;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(out_valid && !in_ready && actual_rec() == held, "R10",
            64'({out_valid, in_ready, actual_rec()}), 64'({2'b10, held}));
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    // byte 0x90 now taken as a plain lead (R1 R10)
    @(negedge clk);
    in_valid = 1'b0;
    wait_rec();
    check(!out_is_vex && out_lead == 8'h90 && !out_follow_valid, "R10",
          64'({out_is_vex, out_lead, out_follow_valid}), 64'({1'b0, 8'h90, 1'b0}));
    pop();

    // R11: reset in the middle of a three-byte prefix
    push(8'hC4); push(8'hE1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!out_valid && in_ready, "R11", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    push(8'h0F);
    wait_rec();
    check(!out_is_vex && out_lead == 8'h0F && !out_follow_valid, "R11",
          64'({out_is_vex, out_lead, out_follow_valid}), 64'({1'b0, 8'h0F, 1'b0}));
    pop();

    finish_run();
  end

endmodule